// File: doc/BRIEF.md
# Cipher Block Start and Ready Sequencer

This block decides when a block cipher datapath begins work on a block and when the result is marked as ready. It watches single-cycle write strobes to four input-data words, a single-cycle read strobe for the output-data words, and a manual start strobe. A small set of configuration inputs selects how a block is launched, what clears the ready flag, the key length, a processing delay multiplier and whether a second input slot may be used.

The datapath gets a one-cycle `core_start` pulse. The block does not contain the round logic. It models the time the datapath takes with a down-counter loaded at start, shows that interval on `busy`, and pulses `done` on the last busy cycle. A ready flag and a sticky overrun flag are the only persistent status. A second input slot lets a new block be accepted while the current one runs, so that the next operation follows with no gap.

Top module: `cipher_start_seq`

## Requirements
- R1: After a `core_start` pulse, `busy` is high for exactly N × (`cfg_delay` + 1) cycles. N is 10 when `cfg_ksize` is 0, 12 when it is 1, and 14 when it is 2 or 3. `done` is high on the last of those cycles, and `data_rdy` is high from the following cycle.
- R2: When `cfg_smode` is 0 or 3 (manual), an idle block starts only on `start_strobe`. Data writes alone never start it.
- R3: When `cfg_smode` is 1 (auto), an idle block starts on the write that completes the set of all four word indices written since the previous start. The order does not matter, and repeated writes to one index count once.
- R4: When `cfg_smode` is 2 (word-zero), an idle block starts on a write with `in_wr_idx` equal to 0. Writes to indices 1 to 3 never start it.
- R5: With `cfg_last_out` at 0, `data_rdy` clears the cycle after an `out_rd` strobe, and input writes leave it set.
- R6: With `cfg_last_out` at 1, `data_rdy` clears the cycle after any `in_wr_en` strobe, and `out_rd` leaves it set.
- R7: Unless `cfg_dual` is 1 and `cfg_smode` is 2, input writes made while `busy` is high are discarded. They neither start an operation nor count toward the auto-mode word set.
- R8: With `cfg_dual` at 1 and `cfg_smode` at 2, a word-0 write while busy and with the slot empty sets `slot2_full`. The next `core_start` is issued on the `done` cycle, so `busy` stays high across both operations, and `slot2_full` clears at that launch.
- R9: A start request that arrives while `busy` is high and that the second slot cannot absorb is dropped. It sets `overrun` on the next cycle. `overrun` stays set until an `ovr_rd` strobe clears it.
- R10: After reset, `busy`, `done`, `core_start`, `data_rdy`, `slot2_full` and `overrun` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_wr_en | input | 1 | Write strobe for an input-data word |
| in_wr_idx | input | 2 | Index of the input-data word being written |
| out_rd | input | 1 | Read strobe for any output-data word |
| start_strobe | input | 1 | Manual start request |
| ovr_rd | input | 1 | Read of the overrun flag; clears it |
| cfg_smode | input | 2 | Start mode: 0/3 manual, 1 auto, 2 word-zero |
| cfg_last_out | input | 1 | Ready flag cleared by input writes instead of output reads |
| cfg_ksize | input | 2 | Key length code selecting the round count |
| cfg_delay | input | 4 | Processing delay multiplier minus one |
| cfg_dual | input | 1 | Enables the second input slot in word-zero mode |
| core_start | output | 1 | One-cycle start pulse to the datapath |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last cycle of an operation |
| data_rdy | output | 1 | Result available flag |
| slot2_full | output | 1 | Second input slot holds a pending block |
| overrun | output | 1 | Sticky flag for a dropped start request |

## Verification
The assertions assume that every `cfg_*` input stays constant from a `core_start` until the matching `done`. The busy-length check and the slot-origin check compare against the current configuration, so a change in between would make them wrong. The bench changes configuration only while `busy` is low, waiting for idle after each scenario before it reprograms anything. Strobes are treated as single-cycle events: the bench raises each one for exactly one cycle and never issues two input writes in the same cycle, because the port carries only one index.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

  typedef enum logic [1:0] {
    SM_MANUAL = 2'd0,
    SM_AUTO   = 2'd1,
    SM_WORD0  = 2'd2,
    SM_SPARE  = 2'd3
  } start_mode_e;

endpackage

// File: rtl/cseq_timer.sv
module cseq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
    if (load) begin
      busy_d = 1'b1;
      cnt_d  = load_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

endmodule

// File: rtl/cseq_inbuf.sv
module cseq_inbuf #(
  parameter int NWORDS = 4,
  localparam int IDX_W = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_acc,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              mask_clr,
  input  logic              slot_set,
  input  logic              slot_clr,
  output logic [NWORDS-1:0] mask,
  output logic              slot_full
);

  logic [NWORDS-1:0] mask_q, mask_d;
  logic              slot_q, slot_d;
  logic [NWORDS-1:0] hot;

  assign hot = NWORDS'(1) << wr_idx;

  always_comb begin
    mask_d = mask_q;
    if (mask_clr)    mask_d = '0;
    else if (wr_acc) mask_d = mask_q | hot;
    slot_d = slot_q;
    if (slot_set)      slot_d = 1'b1;
    else if (slot_clr) slot_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      slot_q <= 1'b0;
    end else begin
      mask_q <= mask_d;
      slot_q <= slot_d;
    end
  end

  assign mask      = mask_q;
  assign slot_full = slot_q;

endmodule

// File: rtl/cseq_flags.sv
module cseq_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_set,
  input  logic rdy_clr,
  input  logic ovr_set,
  input  logic ovr_clr,
  output logic data_rdy,
  output logic overrun
);

  logic rdy_q, rdy_d;
  logic ovr_q, ovr_d;

  always_comb begin
    rdy_d = rdy_q;
    if (rdy_set)      rdy_d = 1'b1;
    else if (rdy_clr) rdy_d = 1'b0;
    ovr_d = ovr_q;
    if (ovr_set)      ovr_d = 1'b1;
    else if (ovr_clr) ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      ovr_q <= ovr_d;
    end
  end

  assign data_rdy = rdy_q;
  assign overrun  = ovr_q;

endmodule

// File: rtl/cipher_start_seq.sv
module cipher_start_seq #(
  parameter int NWORDS = 4,
  parameter int DLY_W  = 4,
  localparam int IDX_W   = $clog2(NWORDS),
  localparam int MAX_CYC = 14 * (2 ** DLY_W),
  localparam int CNT_W   = $clog2(MAX_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_wr_en,
  input  logic [IDX_W-1:0] in_wr_idx,
  input  logic             out_rd,
  input  logic             start_strobe,
  input  logic             ovr_rd,
  input  logic [1:0]       cfg_smode,
  input  logic             cfg_last_out,
  input  logic [1:0]       cfg_ksize,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic             cfg_dual,
  output logic             core_start,
  output logic             busy,
  output logic             done,
  output logic             data_rdy,
  output logic             slot2_full,
  output logic             overrun
);

  import cseq_pkg::*;

  start_mode_e       smode;
  logic [NWORDS-1:0] mask;
  logic [NWORDS-1:0] wr_hot;
  logic              mask_full;
  logic              dual_path, wr_acc, req;
  logic              start_idle, slot_take, launch, drop;
  logic [CNT_W-1:0]  rounds, dly1, op_len, load_val;

  assign smode     = start_mode_e'(cfg_smode);
  assign dual_path = (smode == SM_WORD0) && cfg_dual;
  assign wr_acc    = in_wr_en && (!busy || dual_path);
  assign wr_hot    = in_wr_en ? (NWORDS'(1) << in_wr_idx) : '0;
  assign mask_full = &(mask | wr_hot);

  always_comb begin
    case (smode)
      SM_AUTO:  req = in_wr_en && mask_full;
      SM_WORD0: req = in_wr_en && (in_wr_idx == '0);
      default:  req = start_strobe;
    endcase
  end

  assign start_idle = req && !busy;
  assign slot_take  = req && busy && dual_path && !slot2_full;
  assign drop       = req && busy && !slot_take;
  assign launch     = done && (slot2_full || slot_take);
  assign core_start = start_idle || launch;

  always_comb begin
    case (cfg_ksize)
      2'd0:    rounds = CNT_W'(10);
      2'd1:    rounds = CNT_W'(12);
      default: rounds = CNT_W'(14);
    endcase
    dly1     = CNT_W'(cfg_delay) + CNT_W'(1);
    op_len   = rounds * dly1;
    load_val = op_len - CNT_W'(1);
  end

  cseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (core_start),
    .load_val (load_val),
    .busy     (busy),
    .done     (done)
  );

  cseq_inbuf #(.NWORDS(NWORDS)) u_inbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_acc    (wr_acc),
    .wr_idx    (in_wr_idx),
    .mask_clr  (core_start),
    .slot_set  (slot_take && !done),
    .slot_clr  (launch),
    .mask      (mask),
    .slot_full (slot2_full)
  );

  cseq_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdy_set  (done),
    .rdy_clr  (cfg_last_out ? in_wr_en : out_rd),
    .ovr_set  (drop),
    .ovr_clr  (ovr_rd),
    .data_rdy (data_rdy),
    .overrun  (overrun)
  );

endmodule

// File: rtl/cseq_chk.sv
module cseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_wr_en,
  input logic [1:0] in_wr_idx,
  input logic       start_strobe,
  input logic [1:0] cfg_smode,
  input logic [1:0] cfg_ksize,
  input logic [3:0] cfg_delay,
  input logic       cfg_dual,
  input logic       core_start,
  input logic       busy,
  input logic       done,
  input logic       data_rdy,
  input logic       slot2_full,
  input logic       overrun
);

  int op_cyc;
  int exp_len;

  always_comb begin
    case (cfg_ksize)
      2'd0:    exp_len = 10 * (int'(cfg_delay) + 1);
      2'd1:    exp_len = 12 * (int'(cfg_delay) + 1);
      default: exp_len = 14 * (int'(cfg_delay) + 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          op_cyc <= 0;
    else if (core_start) op_cyc <= 0;
    else if (busy)       op_cyc <= op_cyc + 1;
  end

  AST_OP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (op_cyc + 1 == exp_len)); // R1
  AST_RDY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> data_rdy); // R1
  AST_MANUAL_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (core_start && !busy && (cfg_smode == 2'd0 || cfg_smode == 2'd3)) |-> start_strobe); // R2
  AST_WORD0_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (core_start && !busy && cfg_smode == 2'd2) |-> (in_wr_en && in_wr_idx == 2'd0)); // R4
  AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> (!busy || done)); // R8
  AST_START_MAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> busy); // R1
  AST_SLOT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot2_full) |-> $past(cfg_dual && cfg_smode == 2'd2)); // R8
  AST_OVERRUN_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(busy)); // R9

endmodule

bind cipher_start_seq cseq_chk u_cseq_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_wr_en     (in_wr_en),
  .in_wr_idx    (in_wr_idx),
  .start_strobe (start_strobe),
  .cfg_smode    (cfg_smode),
  .cfg_ksize    (cfg_ksize),
  .cfg_delay    (cfg_delay),
  .cfg_dual     (cfg_dual),
  .core_start   (core_start),
  .busy         (busy),
  .done         (done),
  .data_rdy     (data_rdy),
  .slot2_full   (slot2_full),
  .overrun      (overrun)
);

// File: tb/test_cipher_start_seq.sv
module test_cipher_start_seq;

  logic       clk;
  logic       rst_n;
  logic       in_wr_en;
  logic [1:0] in_wr_idx;
  logic       out_rd;
  logic       start_strobe;
  logic       ovr_rd;
  logic [1:0] cfg_smode;
  logic       cfg_last_out;
  logic [1:0] cfg_ksize;
  logic [3:0] cfg_delay;
  logic       cfg_dual;
  logic       core_start;
  logic       busy;
  logic       done;
  logic       data_rdy;
  logic       slot2_full;
  logic       overrun;

  int n_chk = 0;
  int n_err = 0;
  logic last_go;

  cipher_start_seq i_cipher_start_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_wr_en     (in_wr_en),
    .in_wr_idx    (in_wr_idx),
    .out_rd       (out_rd),
    .start_strobe (start_strobe),
    .ovr_rd       (ovr_rd),
    .cfg_smode    (cfg_smode),
    .cfg_last_out (cfg_last_out),
    .cfg_ksize    (cfg_ksize),
    .cfg_delay    (cfg_delay),
    .cfg_dual     (cfg_dual),
    .core_start   (core_start),
    .busy         (busy),
    .done         (done),
    .data_rdy     (data_rdy),
    .slot2_full   (slot2_full),
    .overrun      (overrun)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx);
    in_wr_en  = 1'b1;
    in_wr_idx = idx;
    #1 last_go = core_start;
    @(negedge clk);
    in_wr_en = 1'b0;
  endtask

  task automatic strobe();
    start_strobe = 1'b1;
    #1 last_go = core_start;
    @(negedge clk);
    start_strobe = 1'b0;
  endtask

  task automatic rd_out();
    out_rd = 1'b1;
    @(negedge clk);
    out_rd = 1'b0;
  endtask

  task automatic rd_ovr();
    ovr_rd = 1'b1;
    @(negedge clk);
    ovr_rd = 1'b0;
  endtask

  task automatic count_busy(inout int n);
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R10", "busy", int'(busy), 0);
    check("R10", "data_rdy", int'(data_rdy), 0);
    check("R10", "overrun", int'(overrun), 0);
    check("R10", "slot2_full", int'(slot2_full), 0);
    check("R10", "core_start", int'(core_start), 0);
  endtask

  task automatic t_manual(input logic [1:0] ks, input logic [3:0] dl, input int exp);
    int n = 0;
    cfg_smode = 2'd0; cfg_ksize = ks; cfg_delay = dl; cfg_dual = 1'b0;
    for (int i = 0; i < 4; i++) wr(2'(i));
    check("R2", "no start from writes", int'(busy), 0);
    strobe();
    check("R2", "strobe starts", int'(last_go), 1);
    count_busy(n);
    check("R1", "busy length", n, exp);
    check("R1", "ready after done", int'(data_rdy), 1);
  endtask

  task automatic t_auto();
    int n = 0;
    cfg_smode = 2'd1; cfg_ksize = 2'd0; cfg_delay = 4'd0;
    wr(2'd2); wr(2'd0); wr(2'd3);
    check("R3", "three words no start", int'(busy), 0);
    wr(2'd1);
    check("R3", "fourth word starts", int'(last_go), 1);
    count_busy(n);
    wr(2'd0); wr(2'd0); wr(2'd1); wr(2'd2);
    check("R3", "repeat index no start", int'(busy), 0);
    wr(2'd3);
    check("R3", "set complete starts", int'(last_go), 1);
    count_busy(n);
  endtask

  task automatic t_word0();
    int n = 0;
    cfg_smode = 2'd2; cfg_dual = 1'b0;
    wr(2'd1); wr(2'd2); wr(2'd3);
    check("R4", "other words no start", int'(busy), 0);
    wr(2'd0);
    check("R4", "word0 starts", int'(last_go), 1);
    count_busy(n);
  endtask

  task automatic t_ready_clear();
    int n = 0;
    cfg_smode = 2'd0; cfg_last_out = 1'b0;
    strobe(); count_busy(n);
    check("R5", "ready set", int'(data_rdy), 1);
    wr(2'd1);
    check("R5", "write keeps ready", int'(data_rdy), 1);
    rd_out();
    check("R5", "read clears ready", int'(data_rdy), 0);
    cfg_last_out = 1'b1;
    strobe(); count_busy(n);
    rd_out();
    check("R6", "read keeps ready", int'(data_rdy), 1);
    wr(2'd2);
    check("R6", "write clears ready", int'(data_rdy), 0);
    cfg_last_out = 1'b0;
  endtask

  task automatic t_dual_off();
    int n = 0;
    cfg_smode = 2'd1; cfg_dual = 1'b0;
    wr(2'd0); wr(2'd1); wr(2'd2); wr(2'd3);
    wr(2'd0); wr(2'd1); wr(2'd2);
    count_busy(n);
    wr(2'd3);
    check("R7", "busy writes discarded", int'(last_go), 0);
    check("R7", "no overrun in auto", int'(overrun), 0);
    wr(2'd0); wr(2'd1);
    check("R7", "idle writes counted", int'(busy), 0);
    wr(2'd2);
    check("R7", "start after idle set", int'(last_go), 1);
    count_busy(n);
    cfg_smode = 2'd2;
    wr(2'd0);
    wr(2'd0);
    check("R9", "dropped write flags overrun", int'(overrun), 1);
    check("R7", "no slot without dual", int'(slot2_full), 0);
    n = 0;
    count_busy(n);
    @(negedge clk);
    check("R7", "no second operation", int'(busy), 0);
    rd_ovr();
    check("R9", "read clears overrun", int'(overrun), 0);
  endtask

  task automatic t_dual_on();
    int n = 0;
    cfg_smode = 2'd2; cfg_dual = 1'b1; cfg_ksize = 2'd0; cfg_delay = 4'd0;
    wr(2'd0);
    wr(2'd0);
    n = 1;
    check("R8", "slot filled", int'(slot2_full), 1);
    count_busy(n);
    check("R8", "back to back length", n, 20);
    check("R8", "slot drained", int'(slot2_full), 0);
    check("R8", "no overrun", int'(overrun), 0);
    wr(2'd0); wr(2'd0); wr(2'd0);
    check("R9", "full slot overrun", int'(overrun), 1);
    n = 0;
    count_busy(n);
    rd_ovr();
    check("R9", "overrun cleared", int'(overrun), 0);
    cfg_dual = 1'b0;
  endtask

  task automatic t_manual_ovr();
    int n = 0;
    cfg_smode = 2'd3; cfg_ksize = 2'd0; cfg_delay = 4'd1;
    strobe();
    strobe();
    n = 1;
    check("R9", "strobe while busy", int'(overrun), 1);
    count_busy(n);
    check("R9", "single operation only", n, 20);
    @(negedge clk);
    check("R9", "overrun sticky", int'(overrun), 1);
    rd_ovr();
    check("R9", "overrun cleared manual", int'(overrun), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_wr_en = 1'b0; in_wr_idx = 2'd0; out_rd = 1'b0;
    start_strobe = 1'b0; ovr_rd = 1'b0; cfg_smode = 2'd0; cfg_last_out = 1'b0;
    cfg_ksize = 2'd0; cfg_delay = 4'd0; cfg_dual = 1'b0; last_go = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_manual(2'd0, 4'd0, 10);
    t_manual(2'd1, 4'd2, 36);
    t_manual(2'd2, 4'd15, 224);
    t_manual(2'd3, 4'd1, 28);
    t_auto();
    t_word0();
    t_ready_clear();
    t_dual_off();
    t_dual_on();
    t_manual_ovr();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

endmodule